// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that copies a run of equal-width elements between a fixed peripheral location and a memory buffer whose address steps upward. A transfer is either described directly by four working-register inputs (one-shot mode) or by a chain of four-word descriptors held in memory (chain mode), which the channel reads over the same master port it uses for data. In each descriptor, the fourth word links to the next one and carries a two-bit control code in its low bits: bit 1 selects follow-on versus end of chain, and bit 0 asks for an interrupt when that descriptor finishes. The size word packs an element-width code above the element count.

Every element waits for a single ready line from the peripheral. Then the channel reads the element from the source and writes it to the destination. Each bus access is one request held until its response. A controller starts the channel by moving the mode input from an inactive value to an active one, and stops it by making the mode inactive again. Progress is visible as a two-bit state code, an interrupt pulse and a sticky error flag.

Top module: `ldma_channel`

## Requirements
- R1: The channel starts only when `mode_i` changes from an inactive value (0 or 3) to 1 (chain) or 2 (one-shot) while idle. A mode held active after completion does not restart it. An inactive mode while busy returns the channel to idle on the next clock edge with no interrupt and no further bus access.
- R2: In one-shot mode the channel copies `cfg_dev_i`, `cfg_mem_i`, `cfg_size_i` and `cfg_next_i` at start and runs exactly one transfer. The follow bit (bit 1) of the link value is ignored. An interrupt pulse follows completion when bit 0 is set.
- R3: In chain mode the first descriptor address is `cfg_next_i` with its two low bits cleared. A descriptor is four 32-bit word reads at offsets 0, 4, 8 and 12, holding in order the device address, memory address, size word and link word.
- R4: Link word code (bits 1:0): 0 ends without interrupt, 1 ends with interrupt, 2 follows without interrupt, 3 follows with interrupt. The next descriptor address is the link word with bits 1:0 cleared. The interrupt for a descriptor is raised when its last element is written.
- R5: Size word bits 13:12 give the element width: 3 is 1 byte, 2 is 2 bytes, 0 is 4 bytes, reported on `bus_size_o` as 0, 1 and 2. The memory address advances by the width after each element. The device address stays fixed.
- R6: Size word bits 11:0 are the element count, and a count of 0 completes with no data access. A count above 0x3FF for 1- or 2-byte elements, above 0x7FF for 4-byte elements, or width code 1 sets `err_o`, pulses `irq_o` and returns to idle with no data access.
- R7: With `dir_i`=1 each element is read at the memory address and written to the device address. With `dir_i`=0 it is read at the device address and written to memory. Write data carries the element right-justified with the unused upper bits zero.
- R8: Before each element the channel waits until `prdy_i` is high.
- R9: `state_o` reports 0 idle, 1 descriptor read, 2 waiting (including size check and peripheral wait), 3 data read or write.
- R10: A response with `bus_err_i` set sets `err_o`, pulses `irq_o` and returns the channel to idle. `err_o` stays set until the next start.
- R11: `bus_req_o` is high only in states 1 and 3. A request keeps its address until `bus_rvalid_i` completes it, with one access outstanding at a time.
- R12: `irq_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 off, 1 chain, 2 one-shot, 3 treated as off |
| dir_i | input | 1 | 1 memory to device, 0 device to memory; sampled at start |
| cfg_dev_i | input | 32 | Device address (one-shot) |
| cfg_mem_i | input | 32 | Memory start address (one-shot) |
| cfg_size_i | input | 14 | Width code [13:12] and element count [11:0] (one-shot) |
| cfg_next_i | input | 32 | Link value: first descriptor address (chain) or control code (one-shot) |
| prdy_i | input | 1 | Peripheral ready for the next element |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | 32 | Byte address of the access |
| bus_size_o | output | 2 | Access width as log2 of bytes |
| bus_wdata_o | output | 32 | Write data, right-justified |
| bus_rvalid_i | input | 1 | Response: completes the pending access |
| bus_rdata_i | input | 32 | Read data, right-justified |
| bus_err_i | input | 1 | Error response, valid with `bus_rvalid_i` |
| state_o | output | 2 | Channel state code |
| irq_o | output | 1 | Completion or error interrupt pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions check the cycle-level rules on every cycle: an inactive mode ends any activity at the next edge, a request is held with a steady address until its response, requests appear only in the descriptor-read and data states, the interrupt is one cycle wide, and the error flag always rises together with an interrupt. The scenarios are the only place where the transferred data can be seen. They cover the placement and width masking of elements in memory and at the device, the descriptor walk with its follow and interrupt codes, the count limits per width, zero-length descriptors, and the absence of a restart while the mode is held. Those results depend on memory contents and counts across many cycles, which a single-cycle property cannot observe.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_WAIT,
        S_READ,
        S_WRITE
    } ldma_st_e;

    localparam logic [1:0] MODE_OFF    = 2'd0;
    localparam logic [1:0] MODE_CHAIN  = 2'd1;
    localparam logic [1:0] MODE_SINGLE = 2'd2;

    localparam logic [1:0] SC_IDLE = 2'd0;
    localparam logic [1:0] SC_DESC = 2'd1;
    localparam logic [1:0] SC_WAIT = 2'd2;
    localparam logic [1:0] SC_XFER = 2'd3;

    localparam logic [1:0] WC_BYTE = 2'd3;
    localparam logic [1:0] WC_HALF = 2'd2;
    localparam logic [1:0] WC_WORD = 2'd0;

endpackage

// File: rtl/ldma_size_decode.sv
module ldma_size_decode
    import ldma_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int SHORT_MAX = 1023,
    parameter int LONG_MAX  = 2047
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       wcode_i,
    output logic [1:0]       lg2_o,
    output logic             legal_o
);
    always_comb begin
        lg2_o   = 2'd2;
        legal_o = 1'b0;
        case (wcode_i)
            WC_BYTE: begin
                lg2_o   = 2'd0;
                legal_o = (count_i <= CNT_W'(SHORT_MAX));
            end
            WC_HALF: begin
                lg2_o   = 2'd1;
                legal_o = (count_i <= CNT_W'(SHORT_MAX));
            end
            WC_WORD: begin
                lg2_o   = 2'd2;
                legal_o = (count_i <= CNT_W'(LONG_MAX));
            end
            default: begin
                lg2_o   = 2'd2;
                legal_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ldma_state_enc.sv
module ldma_state_enc
    import ldma_pkg::*;
(
    input  ldma_st_e   st_i,
    output logic [1:0] code_o
);
    always_comb begin
        case (st_i)
            S_IDLE:          code_o = SC_IDLE;
            S_FETCH:         code_o = SC_DESC;
            S_CHECK, S_WAIT: code_o = SC_WAIT;
            default:         code_o = SC_XFER;
        endcase
    end
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
    import ldma_pkg::*;
#(
    parameter int DW         = 32,
    parameter int CNT_W      = 12,
    parameter int WSEL_LSB   = 12,
    parameter int SHORT_MAX  = 1023,
    parameter int LONG_MAX   = 2047,
    parameter int DESC_WORDS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_i,
    input  logic                  dir_i,
    input  logic [DW-1:0]         cfg_dev_i,
    input  logic [DW-1:0]         cfg_mem_i,
    input  logic [WSEL_LSB+1:0]   cfg_size_i,
    input  logic [DW-1:0]         cfg_next_i,
    input  logic                  prdy_i,
    output logic                  bus_req_o,
    output logic                  bus_we_o,
    output logic [DW-1:0]         bus_addr_o,
    output logic [1:0]            bus_size_o,
    output logic [DW-1:0]         bus_wdata_o,
    input  logic                  bus_rvalid_i,
    input  logic [DW-1:0]         bus_rdata_i,
    input  logic                  bus_err_i,
    output logic [1:0]            state_o,
    output logic                  irq_o,
    output logic                  err_o
);
    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

    typedef struct packed {
        ldma_st_e          st;
        logic              act_prev;
        logic              dir;
        logic              single;
        logic [IDX_W-1:0]  idx;
        logic [DW-1:0]     ptr;
        logic [DW-1:0]     dev;
        logic [DW-1:0]     mem;
        logic [CNT_W-1:0]  cnt_raw;
        logic [1:0]        wcode;
        logic [DW-1:0]     link;
        logic [DW-1:0]     data;
        logic [CNT_W-1:0]  cnt;
        logic              irq;
        logic              err;
    } regs_t;

    regs_t q, d;

    logic [1:0]    lg2;
    logic          size_ok;
    logic          act;
    logic          fin;
    logic [DW-1:0] src_addr;
    logic [DW-1:0] dst_addr;
    logic [DW-1:0] lane_mask;

    ldma_size_decode #(
        .CNT_W    (CNT_W),
        .SHORT_MAX(SHORT_MAX),
        .LONG_MAX (LONG_MAX)
    ) u_size (
        .count_i (q.cnt_raw),
        .wcode_i (q.wcode),
        .lg2_o   (lg2),
        .legal_o (size_ok)
    );

    ldma_state_enc u_enc (
        .st_i   (q.st),
        .code_o (state_o)
    );

    always_comb begin
        case (lg2)
            2'd0:    lane_mask = {{(DW-8){1'b0}}, 8'hFF};
            2'd1:    lane_mask = {{(DW-16){1'b0}}, 16'hFFFF};
            default: lane_mask = '1;
        endcase
    end

    assign act      = (mode_i == MODE_CHAIN) || (mode_i == MODE_SINGLE);
    assign src_addr = q.dir ? q.mem : q.dev;
    assign dst_addr = q.dir ? q.dev : q.mem;

    always_comb begin
        d           = q;
        d.irq       = 1'b0;
        d.act_prev  = act;
        fin         = 1'b0;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_size_o  = lg2;
        bus_wdata_o = '0;

        case (q.st)
            S_IDLE: begin
                if (act && !q.act_prev) begin
                    d.dir    = dir_i;
                    d.err    = 1'b0;
                    d.single = (mode_i == MODE_SINGLE);
                    d.link   = cfg_next_i;
                    if (mode_i == MODE_SINGLE) begin
                        d.dev     = cfg_dev_i;
                        d.mem     = cfg_mem_i;
                        d.cnt_raw = cfg_size_i[CNT_W-1:0];
                        d.wcode   = cfg_size_i[WSEL_LSB +: 2];
                        d.st      = S_CHECK;
                    end else begin
                        d.ptr = {cfg_next_i[DW-1:2], 2'b00};
                        d.idx = '0;
                        d.st  = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                bus_req_o  = 1'b1;
                bus_addr_o = q.ptr + DW'({q.idx, 2'b00});
                bus_size_o = 2'd2;
                if (bus_rvalid_i) begin
                    if (bus_err_i) begin
                        d.err = 1'b1;
                        d.irq = 1'b1;
                        d.st  = S_IDLE;
                    end else begin
                        case (q.idx)
                            IDX_W'(0): d.dev = bus_rdata_i;
                            IDX_W'(1): d.mem = bus_rdata_i;
                            IDX_W'(2): begin
                                d.cnt_raw = bus_rdata_i[CNT_W-1:0];
                                d.wcode   = bus_rdata_i[WSEL_LSB +: 2];
                            end
                            default:   d.link = bus_rdata_i;
                        endcase
                        if (q.idx == IDX_LAST) begin
                            d.st = S_CHECK;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
            end
            S_CHECK: begin
                if (!size_ok) begin
                    d.err = 1'b1;
                    d.irq = 1'b1;
                    d.st  = S_IDLE;
                end else if (q.cnt_raw == '0) begin
                    fin = 1'b1;
                end else begin
                    d.cnt = q.cnt_raw;
                    d.st  = S_WAIT;
                end
            end
            S_WAIT: begin
                if (prdy_i) begin
                    d.st = S_READ;
                end
            end
            S_READ: begin
                bus_req_o  = 1'b1;
                bus_addr_o = src_addr;
                if (bus_rvalid_i) begin
                    if (bus_err_i) begin
                        d.err = 1'b1;
                        d.irq = 1'b1;
                        d.st  = S_IDLE;
                    end else begin
                        d.data = bus_rdata_i & lane_mask;
                        d.st   = S_WRITE;
                    end
                end
            end
            S_WRITE: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = dst_addr;
                bus_wdata_o = q.data;
                if (bus_rvalid_i) begin
                    if (bus_err_i) begin
                        d.err = 1'b1;
                        d.irq = 1'b1;
                        d.st  = S_IDLE;
                    end else begin
                        d.mem = q.mem + (DW'(1) << lg2);
                        d.cnt = q.cnt - 1'b1;
                        if (q.cnt == CNT_W'(1)) begin
                            fin = 1'b1;
                        end else begin
                            d.st = S_WAIT;
                        end
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (fin) begin
            d.irq = q.link[0];
            if (!q.single && q.link[1]) begin
                d.ptr = {q.link[DW-1:2], 2'b00};
                d.idx = '0;
                d.st  = S_FETCH;
            end else begin
                d.st = S_IDLE;
            end
        end

        if ((q.st != S_IDLE) && !act) begin
            d.st  = S_IDLE;
            d.irq = 1'b0;
            d.err = q.err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign irq_o = q.irq;
    assign err_o = q.err;

endmodule

// File: rtl/ldma_channel_chk.sv
module ldma_channel_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          bus_req_o,
    input logic          bus_rvalid_i,
    input logic [DW-1:0] bus_addr_o,
    input logic [1:0]    state_o,
    input logic          irq_o,
    input logic          err_o
);
    logic act;
    assign act = (mode_i == 2'd1) || (mode_i == 2'd2);

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0 && !act) |=> (state_o == 2'd0)) else $error("abort"); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_rvalid_i && act) |=> (bus_req_o && $stable(bus_addr_o))) else $error("req hold"); // R11

    AST_REQ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> (state_o == 2'd1 || state_o == 2'd3)) else $error("req state"); // R9

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o) else $error("irq width"); // R12

    AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> irq_o) else $error("err irq"); // R10

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (state_o == 2'd0)) else $error("err idle"); // R6
endmodule

bind ldma_channel ldma_channel_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .bus_req_o    (bus_req_o),
    .bus_rvalid_i (bus_rvalid_i),
    .bus_addr_o   (bus_addr_o),
    .state_o      (state_o),
    .irq_o        (irq_o),
    .err_o        (err_o)
);

// File: tb/sim_ldma_channel.sv
module sim_ldma_channel;
    localparam logic [31:0] DEV = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        dir_i = 1'b0;
    logic [31:0] cfg_dev_i = '0, cfg_mem_i = '0, cfg_next_i = '0;
    logic [13:0] cfg_size_i = '0;
    logic        prdy_i = 1'b1;
    logic        bus_req_o, bus_we_o;
    logic [31:0] bus_addr_o, bus_wdata_o;
    logic [1:0]  bus_size_o;
    logic        bus_rvalid_i = 1'b0, bus_err_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;
    logic [1:0]  state_o;
    logic        irq_o, err_o;

    int n_chk = 0, n_err = 0;
    int irq_cnt = 0, dev_rd = 0, dev_wr = 0;
    logic [7:0]  mem [0:1023];
    logic [31:0] dev_log [0:15];

    always #5 clk = ~clk;

    ldma_channel u0 (.*);

    function automatic int ix(input logic [31:0] a, input int k);
        return (int'(a[9:0]) + k) & 1023;
    endfunction

    always @(posedge clk) begin
        bus_rvalid_i <= 1'b0;
        bus_err_i    <= 1'b0;
        if (irq_o) irq_cnt <= irq_cnt + 1;
        if (bus_req_o && !bus_rvalid_i) begin
            bus_rvalid_i <= 1'b1;
            if (bus_addr_o[31:12] == 20'h0000F) begin
                bus_err_i <= 1'b1;
            end else if (bus_addr_o == DEV) begin
                if (bus_we_o) begin
                    dev_log[dev_wr & 15] <= bus_wdata_o;
                    dev_wr <= dev_wr + 1;
                end else begin
                    bus_rdata_i <= 32'hD000_0000 + 32'(dev_rd);
                    dev_rd <= dev_rd + 1;
                end
            end else if (bus_we_o) begin
                mem[ix(bus_addr_o, 0)] <= bus_wdata_o[7:0];
                if (bus_size_o != 2'd0) mem[ix(bus_addr_o, 1)] <= bus_wdata_o[15:8];
                if (bus_size_o == 2'd2) begin
                    mem[ix(bus_addr_o, 2)] <= bus_wdata_o[23:16];
                    mem[ix(bus_addr_o, 3)] <= bus_wdata_o[31:24];
                end
            end else begin
                bus_rdata_i <= {mem[ix(bus_addr_o, 3)], mem[ix(bus_addr_o, 2)],
                                mem[ix(bus_addr_o, 1)], mem[ix(bus_addr_o, 0)]};
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[(a + k) & 1023] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] get32(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    task automatic start(input logic [1:0] m, input logic dir, input logic [31:0] dv,
                         input logic [31:0] mm, input logic [13:0] sz, input logic [31:0] nx);
        @(negedge clk) mode_i = 2'd0;
        @(negedge clk);
        dir_i = dir; cfg_dev_i = dv; cfg_mem_i = mm; cfg_size_i = sz; cfg_next_i = nx;
        mode_i = m;
    endtask

    task automatic wait_done();
        int lim = 0;
        @(negedge clk);
        while (state_o != 2'd0 && lim < 40000) begin
            @(negedge clk);
            lim++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset state", 32'(state_o), 0);
        chk("R12 reset irq", 32'(irq_o), 0);
        chk("R10 reset err", 32'(err_o), 0);
        chk("R11 reset req", 32'(bus_req_o), 0);
    endtask

    task automatic t_single_in();
        int b = dev_rd, i0 = irq_cnt;
        put32(32'h110, 32'h5A5A5A5A);
        start(2'd2, 1'b0, DEV, 32'h100, 14'h0004, 32'h1);
        wait_done();
        for (int k = 0; k < 4; k++)
            chk("R2 R7 word to memory", get32(32'h100 + 4*k), 32'hD000_0000 + 32'(b + k));
        chk("R5 beyond buffer untouched", get32(32'h110), 32'h5A5A5A5A);
        chk("R2 irq on code 1", 32'(irq_cnt - i0), 1);
        chk("R10 no error", 32'(err_o), 0);
        repeat (20) @(negedge clk);
        chk("R1 held mode no restart state", 32'(state_o), 0);
        chk("R1 held mode no restart reads", 32'(dev_rd - b), 4);
    endtask

    task automatic t_single_out_byte();
        int w = dev_wr, i0 = irq_cnt;
        put32(32'h200, 32'h44332211);
        start(2'd2, 1'b1, DEV, 32'h200, 14'h3003, 32'h2);
        wait_done();
        chk("R7 three device writes", 32'(dev_wr - w), 3);
        chk("R5 R7 byte 0", dev_log[(w + 0) & 15], 32'h11);
        chk("R5 R7 byte 1", dev_log[(w + 1) & 15], 32'h22);
        chk("R5 R7 byte 2", dev_log[(w + 2) & 15], 32'h33);
        chk("R2 follow ignored, no irq", 32'(irq_cnt - i0), 0);
    endtask

    task automatic t_chain_half();
        int b = dev_rd, i0 = irq_cnt;
        put32(32'h300, DEV); put32(32'h304, 32'h380); put32(32'h308, 32'h2002); put32(32'h30C, 32'h322);
        put32(32'h320, DEV); put32(32'h324, 32'h390); put32(32'h328, 32'h2001); put32(32'h32C, 32'h1);
        put32(32'h384, 32'hEEEEEEEE);
        start(2'd1, 1'b0, 32'h0, 32'h0, 14'h0, 32'h303);
        @(negedge clk);
        chk("R9 R3 state descriptor read", 32'(state_o), 1);
        wait_done();
        chk("R4 R5 half 0", {16'h0, mem[32'h381], mem[32'h380]}, 32'(b) & 32'hFFFF);
        chk("R4 R5 half 1", {16'h0, mem[32'h383], mem[32'h382]}, 32'(b + 1) & 32'hFFFF);
        chk("R4 second descriptor", {16'h0, mem[32'h391], mem[32'h390]}, 32'(b + 2) & 32'hFFFF);
        chk("R5 after buffer untouched", get32(32'h384), 32'hEEEEEEEE);
        chk("R4 irq only at end", 32'(irq_cnt - i0), 1);
    endtask

    task automatic t_chain_irq_zero();
        int b = dev_rd, i0 = irq_cnt;
        put32(32'h3A4, 32'h77777777);
        put32(32'h3C0, DEV); put32(32'h3C4, 32'h3A0); put32(32'h3C8, 32'h0001); put32(32'h3CC, 32'h3E3);
        put32(32'h3E0, DEV); put32(32'h3E4, 32'h3A4); put32(32'h3E8, 32'h0000); put32(32'h3EC, 32'h0);
        start(2'd1, 1'b0, 32'h0, 32'h0, 14'h0, 32'h3C0);
        wait_done();
        chk("R4 follow with irq data", get32(32'h3A0), 32'hD000_0000 + 32'(b));
        chk("R6 zero count no access", get32(32'h3A4), 32'h77777777);
        chk("R6 zero count no read", 32'(dev_rd - b), 1);
        chk("R4 irq from first only", 32'(irq_cnt - i0), 1);
    endtask

    task automatic t_limits();
        int w, i0;
        w = dev_wr; i0 = irq_cnt;
        start(2'd2, 1'b1, DEV, 32'h0, 14'h3400, 32'h1);
        wait_done();
        chk("R6 byte over limit err", 32'(err_o), 1);
        chk("R6 over limit irq", 32'(irq_cnt - i0), 1);
        chk("R6 over limit no data", 32'(dev_wr - w), 0);
        start(2'd2, 1'b1, DEV, 32'h0, 14'h0800, 32'h0);
        wait_done();
        chk("R6 word over limit err", 32'(err_o), 1);
        start(2'd2, 1'b1, DEV, 32'h0, 14'h1001, 32'h0);
        wait_done();
        chk("R6 width code 1 err", 32'(err_o), 1);
        w = dev_wr;
        start(2'd2, 1'b1, DEV, 32'h0, 14'h07FF, 32'h0);
        wait_done();
        chk("R6 word max count runs", 32'(dev_wr - w), 2047);
        chk("R10 err cleared at start", 32'(err_o), 0);
    endtask

    task automatic t_bus_err();
        int i0 = irq_cnt;
        start(2'd1, 1'b0, 32'h0, 32'h0, 14'h0, 32'hF000);
        wait_done();
        chk("R10 fetch error flag", 32'(err_o), 1);
        chk("R10 fetch error irq", 32'(irq_cnt - i0), 1);
        chk("R10 fetch error idle", 32'(state_o), 0);
        start(2'd2, 1'b0, 32'hF004, 32'h100, 14'h0002, 32'h0);
        wait_done();
        chk("R10 data error flag", 32'(err_o), 1);
    endtask

    task automatic t_abort();
        int b = dev_rd, i0 = irq_cnt;
        prdy_i = 1'b0;
        start(2'd2, 1'b0, DEV, 32'h100, 14'h0002, 32'h1);
        @(negedge clk);
        @(negedge clk);
        chk("R8 R9 waits for ready", 32'(state_o), 2);
        mode_i = 2'd0;
        @(negedge clk);
        chk("R1 abort to idle", 32'(state_o), 0);
        prdy_i = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 abort no access", 32'(dev_rd - b), 0);
        chk("R1 abort no irq", 32'(irq_cnt - i0), 0);
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_in();
        t_single_out_byte();
        t_chain_half();
        t_chain_irq_zero();
        t_limits();
        t_bus_err();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1500000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule